// File: doc/BRIEF.md
# Three-Axis Sensor Register Target on a Two-Wire Bus

This block is an I2C target that lets a bus host reach the small register file of a three-axis sensor. The open-drain SCL and SDA lines are brought into the system clock domain through a synchronizer. On that clock the block finds start, repeated start and stop conditions and matches a 7-bit device address. It acknowledges bytes and steps a register pointer as bytes move in either direction. The system clock must run at least 16 times faster than SCL.

The register space holds two configuration bytes and a mode byte, all writable from the bus and presented to the core as parallel outputs. It also holds six read-only data bytes that show the latest X, Z and Y sample. The core hands in a new sample with a one-cycle valid strobe. Once a host starts reading the data block, the six bytes stay frozen until each of them has been fetched. A sample that arrives in the meantime is parked and shown afterwards. A host that reads past the last data byte wraps back to the first one.

Top module: `snsr_i2c_target`

## Requirements
- R1: A falling SDA while SCL is high starts a transaction, and a rising SDA while SCL is high ends it. The target changes its own SDA drive only while SCL is low. Bits clocked with no start before them get no response.
- R2: A start that arrives inside a transaction, with no stop before it, begins a fresh address phase that is decoded normally.
- R3: The first byte after a start carries the 7-bit address in bits 7..1 and the direction in bit 0 (1 = read, 0 = write). The target responds only to address 0x1E, which gives byte 0x3C for a write and 0x3D for a read. Any other address gets a NACK, and the target ignores the bus until the next start.
- R4: The target pulls SDA low during the ninth clock after a matching address byte and after every byte written to it.
- R5: In a write, the first byte after the address loads the register pointer. Each later byte goes to the register at the pointer, and the pointer then increases by one. Registers 0 (config A), 1 (config B) and 2 (mode) are writable. Writes to registers 3..8 are acknowledged but change nothing. Reads of registers above 8 return 0x00.
- R6: Reset values are 0x10 for config A, 0x20 for config B and 0x01 for mode. The three registers appear on `cfg_a_o`, `cfg_b_o` and `mode_o`. Writing 0x00 to register 2 selects continuous measurement.
- R7: Registers 3..8 hold X high, X low, Z high, Z low, Y high and Y low, and are sent MSB first. Each byte read advances the pointer, and a read of register 8 moves it back to 3. The pointer is 3 after reset.
- R8: Once any data byte has been read, the six data bytes do not change until all six have been read. A sample strobed in that window is kept (the newest wins) and shown when the sixth distinct byte is fetched.
- R9: If the host answers a read byte with NACK, the target releases SDA and ignores the bus until a start or a stop.
- R10: A sample strobed while no data read is under way appears in the data registers on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| smp_valid | input | 1 | One-cycle strobe for a new sample |
| smp_x | input | 16 | X sample |
| smp_y | input | 16 | Y sample |
| smp_z | input | 16 | Z sample |
| cfg_a_o | output | 8 | Config A register |
| cfg_b_o | output | 8 | Config B register |
| mode_o | output | 8 | Mode register |

## Verification
A sample strobe can land in the same clock as the byte load that either freezes the data block or releases it. The bench makes this happen by holding the strobe high for a whole six-byte read and changing the sample value right after the first byte. The strobe is therefore present in both the freezing cycle and the releasing cycle. The check passes only if all six bytes on the bus come from the sample that was current before the read began, and the next read returns the value present when the block was released.

// File: rtl/snsr_i2c_pkg.sv
package snsr_i2c_pkg;
  localparam int SMP_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WBYTE, ST_WACK, ST_RBYTE, ST_RACK, ST_WAIT
  } bus_st_t;

  localparam logic [7:0] REG_CFG_A      = 8'd0;
  localparam logic [7:0] REG_CFG_B      = 8'd1;
  localparam logic [7:0] REG_MODE       = 8'd2;
  localparam logic [7:0] REG_DATA_FIRST = 8'd3;
  localparam logic [7:0] REG_DATA_LAST  = 8'd8;

  // pointer step on a read: the data block wraps on itself
  function automatic logic [7:0] ptr_advance(input logic [7:0] p);
    return (p == REG_DATA_LAST) ? REG_DATA_FIRST : p + 8'd1;
  endfunction

  // byte index 0..5 of the data block: X hi, X lo, Z hi, Z lo, Y hi, Y lo
  function automatic logic [7:0] sample_byte(input logic [SMP_W-1:0] x,
                                             input logic [SMP_W-1:0] y,
                                             input logic [SMP_W-1:0] z,
                                             input logic [2:0] idx);
    case (idx)
      3'd0:    return x[15:8];
      3'd1:    return x[7:0];
      3'd2:    return z[15:8];
      3'd3:    return z[7:0];
      3'd4:    return y[15:8];
      3'd5:    return y[7:0];
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [STAGES-1:0] scl_chain, sda_chain;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_chain <= '1;
      sda_chain <= '1;
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
    end else begin
      scl_chain <= {scl_chain[STAGES-2:0], scl_i};
      sda_chain <= {sda_chain[STAGES-2:0], sda_i};
      scl_q     <= scl_s;
      sda_q     <= sda_s;
    end
  end

  assign scl_s     = scl_chain[STAGES-1];
  assign sda_s     = sda_chain[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign bus_start = scl_s & scl_q & sda_q & ~sda_s;
  assign bus_stop  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/snsr_regfile.sv
module snsr_regfile
  import snsr_i2c_pkg::*;
#(
  parameter logic [7:0] CFG_A_RST = 8'h10,
  parameter logic [7:0] CFG_B_RST = 8'h20,
  parameter logic [7:0] MODE_RST  = 8'h01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             rd_ld,
  input  logic [7:0]       rd_addr,
  output logic [7:0]       rd_byte,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_x,
  input  logic [SMP_W-1:0] smp_y,
  input  logic [SMP_W-1:0] smp_z,
  output logic [7:0]       cfg_a,
  output logic [7:0]       cfg_b,
  output logic [7:0]       mode
);
  logic [SMP_W-1:0] cur_x, cur_y, cur_z, pend_x, pend_y, pend_z;
  logic             pend_v;
  logic [7:0]       rd_mask, mask_nxt;
  logic             in_blk, blk_rd, blk_done, blk_busy;
  logic [2:0]       blk_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_a <= CFG_A_RST;
      cfg_b <= CFG_B_RST;
      mode  <= MODE_RST;
    end else if (wr_en) begin
      case (wr_addr)
        REG_CFG_A: cfg_a <= wr_data;
        REG_CFG_B: cfg_b <= wr_data;
        REG_MODE:  mode  <= wr_data;
        default: ;
      endcase
    end
  end

  assign in_blk   = (rd_addr >= REG_DATA_FIRST) && (rd_addr <= REG_DATA_LAST);
  assign blk_idx  = 3'(rd_addr - REG_DATA_FIRST);
  assign blk_rd   = rd_ld && in_blk;

  always_comb begin
    mask_nxt = rd_mask;
    if (blk_rd) mask_nxt[blk_idx] = 1'b1;
  end

  assign blk_done = &mask_nxt[5:0];
  assign blk_busy = (rd_mask != 8'd0) || blk_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_mask <= '0;
      cur_x <= '0; cur_y <= '0; cur_z <= '0;
      pend_x <= '0; pend_y <= '0; pend_z <= '0;
      pend_v <= 1'b0;
    end else begin
      rd_mask <= blk_done ? 8'd0 : mask_nxt;
      if (smp_valid) begin
        if (blk_busy && !blk_done) begin
          pend_x <= smp_x; pend_y <= smp_y; pend_z <= smp_z;
          pend_v <= 1'b1;
        end else begin
          cur_x <= smp_x; cur_y <= smp_y; cur_z <= smp_z;
          pend_v <= 1'b0;
        end
      end else if (blk_done && pend_v) begin
        cur_x <= pend_x; cur_y <= pend_y; cur_z <= pend_z;
        pend_v <= 1'b0;
      end
    end
  end

  always_comb begin
    case (rd_addr)
      REG_CFG_A: rd_byte = cfg_a;
      REG_CFG_B: rd_byte = cfg_b;
      REG_MODE:  rd_byte = mode;
      default:   rd_byte = in_blk ? sample_byte(cur_x, cur_y, cur_z, blk_idx) : 8'h00;
    endcase
  end

  assert_data_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mask != 8'd0 && !blk_done) |=> $stable({cur_x, cur_y, cur_z}));

  assert_pending_shown_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_done && pend_v && !smp_valid) |=> (cur_x == $past(pend_x) && cur_z == $past(pend_z)));

  assert_idle_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && rd_mask == 8'd0 && !blk_rd) |=> (cur_y == $past(smp_y)));

  assert_mode_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == REG_MODE) |=> (mode == $past(wr_data)));
endmodule

// File: rtl/snsr_i2c_target.sv
module snsr_i2c_target
  import snsr_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h1E,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] CFG_A_RST   = 8'h10,
  parameter logic [7:0] CFG_B_RST   = 8'h20,
  parameter logic [7:0] MODE_RST    = 8'h01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_x,
  input  logic [SMP_W-1:0] smp_y,
  input  logic [SMP_W-1:0] smp_z,
  output logic [7:0]       cfg_a_o,
  output logic [7:0]       cfg_b_o,
  output logic [7:0]       mode_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  bus_st_t    st;
  logic [3:0] bit_cnt;
  logic [7:0] shreg, tx, ptr, rd_byte;
  logic       is_read, first_wr, m_ack;
  logic       addr_hit, rd_ld, wr_en;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  snsr_regfile #(.CFG_A_RST(CFG_A_RST), .CFG_B_RST(CFG_B_RST), .MODE_RST(MODE_RST)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(ptr), .wr_data(shreg),
    .rd_ld(rd_ld), .rd_addr(ptr), .rd_byte(rd_byte),
    .smp_valid(smp_valid), .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z),
    .cfg_a(cfg_a_o), .cfg_b(cfg_b_o), .mode(mode_o)
  );

  // named events shared by the state machine, the register file and the assertions
  assign addr_hit = (shreg[7:1] == DEV_ADDR);
  assign rd_ld    = scl_fall && ((st == ST_AACK && is_read) || (st == ST_RACK && m_ack));
  assign wr_en    = scl_fall && (st == ST_WBYTE) && (bit_cnt == 4'd8) && !first_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; bit_cnt <= '0; shreg <= '0; tx <= '0;
      ptr <= REG_DATA_FIRST; is_read <= 1'b0; first_wr <= 1'b0;
      m_ack <= 1'b0; sda_oe <= 1'b0;
    end else if (bus_stop) begin
      st <= ST_IDLE; sda_oe <= 1'b0;
    end else if (bus_start) begin
      st <= ST_ADDR; bit_cnt <= '0; sda_oe <= 1'b0;
    end else if (rd_ld) begin
      tx <= rd_byte; ptr <= ptr_advance(ptr);
      sda_oe <= ~rd_byte[7]; bit_cnt <= '0; st <= ST_RBYTE;
    end else begin
      case (st)
        ST_ADDR, ST_WBYTE: begin
          if (scl_rise) begin
            shreg <= {shreg[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (scl_fall && bit_cnt == 4'd8) begin
            bit_cnt <= '0;
            if (st == ST_ADDR) begin
              if (addr_hit) begin
                st <= ST_AACK; sda_oe <= 1'b1;
                is_read <= shreg[0]; first_wr <= 1'b1;
              end else begin
                st <= ST_WAIT;
              end
            end else begin
              st <= ST_WACK; sda_oe <= 1'b1; first_wr <= 1'b0;
              ptr <= first_wr ? shreg : ptr + 8'd1;
            end
          end
        end
        ST_AACK, ST_WACK: if (scl_fall) begin
          sda_oe <= 1'b0; st <= ST_WBYTE;
        end
        ST_RBYTE: if (scl_fall) begin
          if (bit_cnt == 4'd7) begin
            bit_cnt <= '0; sda_oe <= 1'b0; st <= ST_RACK;
          end else begin
            bit_cnt <= bit_cnt + 4'd1;
            tx <= {tx[6:0], 1'b0};
            sda_oe <= ~tx[6];
          end
        end
        ST_RACK: begin
          if (scl_rise) m_ack <= ~sda_s;
          else if (scl_fall) st <= ST_WAIT;
        end
        default: ;
      endcase
    end
  end

  assert_drive_scl_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  assert_restart_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> (st == ST_ADDR && bit_cnt == 4'd0));

  assert_ack_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_AACK || st == ST_WACK) |-> sda_oe);

  assert_ptr_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ld && ptr == REG_DATA_LAST) |=> (ptr == REG_DATA_FIRST));

  assert_nack_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT) |-> !sda_oe);
endmodule

// File: tb/snsr_i2c_target_tb_top.sv
module snsr_i2c_target_tb_top;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe;
  wire  sda_bus = m_sda & ~sda_oe;
  logic smp_valid = 1'b0;
  logic [15:0] sx = '0, sy = '0, sz = '0;
  logic [7:0] cfg_a, cfg_b, mode;

  int n_tests = 0, n_fail = 0;
  logic [7:0] rx [0:7];
  logic ackn;

  snsr_i2c_target dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .smp_valid(smp_valid), .smp_x(sx), .smp_y(sy), .smp_z(sz),
    .cfg_a_o(cfg_a), .cfg_b_o(cfg_b), .mode_o(mode)
  );

  // stimulus x, y, z and the expected six-byte image X hi/lo, Z hi/lo, Y hi/lo
  localparam logic [95:0] VEC [4] = '{
    {16'h1234, 16'h5678, 16'h9ABC, 48'h1234_9ABC_5678},
    {16'hFFFF, 16'h0000, 16'h8001, 48'hFFFF_8001_0000},
    {16'h0080, 16'h7F00, 16'h00FF, 48'h0080_00FF_7F00},
    {16'hA5C3, 16'h3CA5, 16'h5A5A, 48'hA5C3_5A5A_3CA5}
  };

  task automatic chk(input string req, input string what, input logic [47:0] act, input logic [47:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wq;
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; wq; m_scl = 1'b1; wq; m_sda = 1'b0; wq; m_scl = 1'b0; wq;
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; wq; m_scl = 1'b1; wq; m_sda = 1'b1; wq;
  endtask

  task automatic wbit(input logic b);
    m_sda = b; wq; m_scl = 1'b1; wq; wq; m_scl = 1'b0; wq;
  endtask

  task automatic rbit(output logic b);
    m_sda = 1'b1; wq; m_scl = 1'b1; wq; b = sda_bus; wq; m_scl = 1'b0; wq;
  endtask

  task automatic wbyte(input logic [7:0] d, output logic a_n);
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(a_n);
  endtask

  task automatic rbyte(input logic give_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) rbit(d[i]);
    wbit(~give_ack);
  endtask

  task automatic rd_txn(input int n);
    logic a;
    bus_start; wbyte(8'h3D, a);
    for (int i = 0; i < n; i++) rbyte(i < n - 1, rx[i]);
    bus_stop;
  endtask

  task automatic set_ptr(input logic [7:0] p);
    logic a;
    bus_start; wbyte(8'h3C, a); wbyte(p, a); bus_stop;
  endtask

  task automatic pulse_sample(input logic [15:0] x, input logic [15:0] y, input logic [15:0] z);
    @(negedge clk); sx = x; sy = y; sz = z; smp_valid = 1'b1;
    @(negedge clk); smp_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [47:0] six;
    return {rx[0], rx[1], rx[2], rx[3], rx[4], rx[5]};
  endfunction

  initial begin
    repeat (180000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic a0, a1, a2;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    chk("R6", "cfg A reset", 48'(cfg_a), 48'h10);
    chk("R6", "cfg B reset", 48'(cfg_b), 48'h20);
    chk("R6", "mode reset", 48'(mode), 48'h01);
    chk("R1", "SDA released at reset", 48'(sda_oe), 48'h0);

    // table walk: idle sample update and data byte order
    for (int k = 0; k < 4; k++) begin
      pulse_sample(VEC[k][95:80], VEC[k][79:64], VEC[k][63:48]);
      rd_txn(6);
      chk("R10", $sformatf("vector %0d six bytes (R7 order)", k), six(), VEC[k][47:0]);
    end

    // wrap: seventh byte is X high again
    rd_txn(7);
    chk("R7", "bytes before wrap", six(), VEC[3][47:0]);
    chk("R7", "byte after register 8", 48'(rx[6]), 48'hA5);
    set_ptr(8'h03); rd_txn(6);
    chk("R7", "realigned read", six(), VEC[3][47:0]);

    // mode write with acknowledges
    bus_start; wbyte(8'h3C, a0); wbyte(8'h02, a1); wbyte(8'h00, a2); bus_stop;
    chk("R4", "acks on address, pointer, data", {45'd0, a0, a1, a2}, 48'd0);
    chk("R6", "continuous mode selected", 48'(mode), 48'h00);

    // pointer load then two writes
    bus_start; wbyte(8'h3C, a0); wbyte(8'h00, a0); wbyte(8'h11, a0); wbyte(8'h60, a0); bus_stop;
    chk("R5", "cfg A written", 48'(cfg_a), 48'h11);
    chk("R5", "cfg B written at incremented pointer", 48'(cfg_b), 48'h60);

    // repeated start switches to read without stop
    bus_start; wbyte(8'h3C, a0); wbyte(8'h00, a0);
    bus_start; wbyte(8'h3D, a1);
    rbyte(1'b1, rx[0]); rbyte(1'b1, rx[1]); rbyte(1'b0, rx[2]); bus_stop;
    chk("R2", "ack after repeated start", 48'(a1), 48'h0);
    chk("R2", "read from reloaded pointer", {24'd0, rx[0], rx[1], rx[2]}, 48'h116000);

    // writes into the data block change nothing; unmapped register reads zero
    bus_start; wbyte(8'h3C, a0); wbyte(8'h04, a0); wbyte(8'hEE, a1); bus_stop;
    chk("R5", "data write acknowledged", 48'(a1), 48'h0);
    set_ptr(8'h03); rd_txn(6);
    chk("R5", "data block untouched by write", six(), VEC[3][47:0]);
    set_ptr(8'h20); rd_txn(1);
    chk("R5", "unmapped register reads zero", 48'(rx[0]), 48'h00);

    // foreign address
    bus_start; wbyte(8'h42, a0); wbyte(8'h00, a1); bus_stop;
    chk("R3", "foreign address not acknowledged", {46'd0, a0, a1}, 48'h3);
    chk("R3", "mode unchanged after foreign write", 48'(mode), 48'h00);

    // bits without a start
    m_scl = 1'b0; wq;
    wbyte(8'h3C, a0);
    chk("R1", "no response without start", 48'(a0), 48'h1);
    bus_stop;

    // host NACK releases the bus
    set_ptr(8'h03);
    bus_start; wbyte(8'h3D, a0); rbyte(1'b0, rx[0]); rbyte(1'b0, rx[1]); bus_stop;
    chk("R9", "byte before NACK", 48'(rx[0]), 48'hA5);
    chk("R9", "bus released after NACK", 48'(rx[1]), 48'hFF);
    set_ptr(8'h03); rd_txn(6);

    // freeze across a split read
    pulse_sample(16'h1111, 16'h2222, 16'h3333);
    rd_txn(3);
    chk("R8", "first half of block", {24'd0, rx[0], rx[1], rx[2]}, 48'h111133);
    pulse_sample(16'h4444, 16'h5555, 16'h6666);
    rd_txn(3);
    chk("R8", "second half keeps old sample", {24'd0, rx[0], rx[1], rx[2]}, 48'h332222);
    rd_txn(6);
    chk("R8", "parked sample shown after release", six(), 48'h4444_6666_5555);

    // strobe held through lock and release cycles
    @(negedge clk); sx = 16'h7777; sy = 16'h8888; sz = 16'h9999; smp_valid = 1'b1;
    repeat (4) @(negedge clk);
    bus_start; wbyte(8'h3D, a0);
    rbyte(1'b1, rx[0]);
    sx = 16'hAAAA; sy = 16'hBBBB; sz = 16'hCCCC;
    for (int i = 1; i < 6; i++) rbyte(i < 5, rx[i]);
    bus_stop;
    @(negedge clk); smp_valid = 1'b0;
    chk("R8", "coherent bytes with strobe held", six(), 48'h7777_9999_8888);
    rd_txn(6);
    chk("R10", "value at release shown next", six(), 48'hAAAA_CCCC_BBBB);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule